// File: doc/BRIEF.md
# Local Scan Port Chain Builder

This block sits behind a primary test access port and decides which of several local scan ports take part in the active serial path. Each port is either unparked, or parked in a stable TAP state: test-logic-reset, run-test-idle, Pause-DR or Pause-IR. Instructions that reach Update-IR park or unpark the ports selected by a mode register. The block then threads the serial data from the primary data input through the selected, unparked ports, with a one-bit retiming flop after each of them, and back to the primary data output.

Ports are grouped into sections of three. A section in which no port is a member passes data straight through. When every section is empty, a single internal flop closes the loop from data input to data output. The block also drives each port's TMS. An unparked port follows the primary TMS. A parked port gets a constant TMS that keeps its TAP in the chosen state, while its test clock keeps running.

The primary TAP controller is outside this block. It supplies its current state and the current instruction. The block does no electrical tri-stating.

Top module: `lsp_chain_builder`

## Requirements
- R1: After rst_ni is asserted, every port is parked in test-logic-reset (its TMS output is 1), the mode register is zero, and data passes from tdi_i to tdo_o through one internal flop.
- R2: While ir_i is 8'h8E, the mode register works as follows. Capture-DR (state 4'h6) loads the shift register from the mode register. Shift-DR (4'h2) shifts right, with tdi_i entering bit 5 and bit 0 driving tdo_o. Update-DR (4'h5) copies the shift register into the mode register. Test-logic-reset (4'hF) clears the mode register whatever the instruction is.
- R3: A port is a chain member when it is unparked and its mode bit (bit i for port i) is 1. Members are visited from the lowest port number to the highest. Each member's returned data is captured in a pad flop on the rising clock edge, so a path with k members delays data by k cycles.
- R4: A section of three ports with no member is bypassed combinationally. When every section is bypassed, tdo_o equals tdi_i delayed by one cycle.
- R5: At Update-IR (state 4'hD) with ir_i = 8'hE7, every parked or pending port whose mode bit is set becomes unparked. Ports whose mode bit is clear keep their parked state.
- R6: At Update-IR with ir_i = 8'hC5, each unparked port whose mode bit is set is parked in test-logic-reset. It leaves the chain at once and its TMS is held at 1.
- R7: At Update-IR with ir_i = 8'h84, selected unparked ports leave the chain but keep following the primary TMS until the primary state is run-test-idle (4'hC). From then on their TMS is held at 0.
- R8: At Update-IR with ir_i = 8'hC6, selected unparked ports follow the primary TMS until the primary state is Pause-DR (4'h3) or Pause-IR (4'hB). From then on their TMS is held at 0, even after the primary TAP moves on.
- R9: An unparked port's TMS output equals tms_i.
- R10: A port that is not a chain member receives a constant 1 on its data output.
- R11: Any other opcode at Update-IR leaves the park state of every port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tap_state_i | input | 4 | Primary TAP state, standard 4-bit encoding |
| ir_i | input | 8 | Current primary instruction |
| tms_i | input | 1 | Primary TMS |
| tdi_i | input | 1 | Primary serial data in |
| lsp_tdo_i | input | 6 | Data returned by each local port |
| lsp_tdi_o | output | 6 | Data sent to each local port |
| lsp_tms_o | output | 6 | TMS for each local port |
| tdo_o | output | 1 | Primary serial data out |

## Verification
The hardest states to reach are mixed ones: some ports held in different parked states while others are unparked, with the mode register pointing somewhere else. The stimulus builds this up one instruction at a time. It writes a narrow mode value, issues a park or unpark instruction, and widens the mode again, so that each later instruction is shown to touch only its own selection. Chain length is measured with the local ports looped back. A single 1 is launched after a run of zeros, and the bench counts the cycles until the 1 reaches tdo_o. Ports that leave the chain show up as a shorter delay. Parking is observed through the per-port TMS, compared against a toggled primary TMS.

// File: rtl/lsp_gw_pkg.sv
package lsp_gw_pkg;
  localparam logic [3:0] TS_TLR   = 4'hF;
  localparam logic [3:0] TS_RTI   = 4'hC;
  localparam logic [3:0] TS_SELDR = 4'h7;
  localparam logic [3:0] TS_CDR   = 4'h6;
  localparam logic [3:0] TS_SDR   = 4'h2;
  localparam logic [3:0] TS_PDR   = 4'h3;
  localparam logic [3:0] TS_E2DR  = 4'h0;
  localparam logic [3:0] TS_UDR   = 4'h5;
  localparam logic [3:0] TS_PIR   = 4'hB;
  localparam logic [3:0] TS_UIR   = 4'hD;

  localparam logic [7:0] OP_PARK_TLR   = 8'hC5;
  localparam logic [7:0] OP_PARK_RTI   = 8'h84;
  localparam logic [7:0] OP_PARK_PAUSE = 8'hC6;
  localparam logic [7:0] OP_UNPARK     = 8'hE7;
  localparam logic [7:0] OP_MODE       = 8'h8E;

  typedef enum logic [2:0] {
    PS_UNPARKED,
    PS_WAIT_RTI,
    PS_WAIT_PAUSE,
    PS_HELD_TLR,
    PS_HELD_RTI,
    PS_HELD_PDR,
    PS_HELD_PIR
  } park_e;
endpackage

// File: rtl/lsp_park_port.sv
module lsp_park_port
  import lsp_gw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] tap_state_i,
  input  logic [7:0] ir_i,
  input  logic       sel_i,
  input  logic       tms_i,
  output logic       tms_o,
  output logic       active_o
);
  park_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= PS_HELD_TLR;
    end else if (tap_state_i == TS_UIR) begin
      if (sel_i) begin
        case (ir_i)
          OP_PARK_TLR:   if (st_q == PS_UNPARKED) st_q <= PS_HELD_TLR;
          OP_PARK_RTI:   if (st_q == PS_UNPARKED) st_q <= PS_WAIT_RTI;
          OP_PARK_PAUSE: if (st_q == PS_UNPARKED) st_q <= PS_WAIT_PAUSE;
          OP_UNPARK:     st_q <= PS_UNPARKED;
          default:       ;
        endcase
      end
    end else begin
      case (st_q)
        PS_WAIT_RTI:   if (tap_state_i == TS_RTI) st_q <= PS_HELD_RTI;
        PS_WAIT_PAUSE: begin
          if (tap_state_i == TS_PDR) st_q <= PS_HELD_PDR;
          else if (tap_state_i == TS_PIR) st_q <= PS_HELD_PIR;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      PS_HELD_TLR:                          tms_o = 1'b1;
      PS_HELD_RTI, PS_HELD_PDR, PS_HELD_PIR: tms_o = 1'b0;
      default:                              tms_o = tms_i;
    endcase
  end

  assign active_o = (st_q == PS_UNPARKED);

  logic uir_sel;
  assign uir_sel = (tap_state_i == TS_UIR) && sel_i;

  AST_UNPARK_JOINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uir_sel && ir_i == OP_UNPARK) |=> active_o); // R5
  AST_PARK_TLR_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uir_sel && ir_i == OP_PARK_TLR && active_o) |=> (!active_o && tms_o)); // R6
  AST_RTI_SETTLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_WAIT_RTI && tap_state_i == TS_RTI) |=> !tms_o); // R7
  AST_HELD_LOW_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == PS_HELD_RTI || st_q == PS_HELD_PDR || st_q == PS_HELD_PIR) &&
     !(uir_sel && ir_i == OP_UNPARK)) |=> !tms_o); // R8
endmodule

// File: rtl/lsp_mode_reg.sv
module lsp_mode_reg
  import lsp_gw_pkg::*;
#(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       tap_state_i,
  input  logic [7:0]       ir_i,
  input  logic             tdi_i,
  output logic [WIDTH-1:0] mode_o,
  output logic             sout_o
);
  logic [WIDTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      mode_o <= '0;
    end else if (tap_state_i == TS_TLR) begin
      sr_q   <= '0;
      mode_o <= '0;
    end else if (ir_i == OP_MODE) begin
      case (tap_state_i)
        TS_CDR:  sr_q   <= mode_o;
        TS_SDR:  sr_q   <= {tdi_i, sr_q[WIDTH-1:1]};
        TS_UDR:  mode_o <= sr_q;
        default: ;
      endcase
    end
  end

  assign sout_o = sr_q[0];

  AST_MODE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_state_i == TS_TLR) |=> (mode_o == '0)); // R2
endmodule

// File: rtl/lsp_chain_section.sv
module lsp_chain_section #(
  parameter int unsigned PORTS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PORTS-1:0] member_i,
  input  logic             sdi_i,
  input  logic [PORTS-1:0] lsp_tdo_i,
  output logic [PORTS-1:0] lsp_tdi_o,
  output logic             sdo_o,
  output logic             bypass_o
);
  logic [PORTS:0]   link;
  logic [PORTS-1:0] pad_q;

  assign link[0] = sdi_i;

  for (genvar i = 0; i < PORTS; i++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pad_q[i] <= 1'b0;
      else         pad_q[i] <= lsp_tdo_i[i];
    end
    assign lsp_tdi_o[i] = member_i[i] ? link[i] : 1'b1;
    assign link[i+1]    = member_i[i] ? pad_q[i] : link[i];
  end

  assign sdo_o    = link[PORTS];
  assign bypass_o = ~|member_i;
endmodule

// File: rtl/lsp_chain_builder.sv
module lsp_chain_builder
  import lsp_gw_pkg::*;
#(
  parameter int unsigned N_SEC     = 2,
  parameter int unsigned SEC_PORTS = 3,
  localparam int unsigned N_PORTS  = N_SEC * SEC_PORTS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         tap_state_i,
  input  logic [7:0]         ir_i,
  input  logic               tms_i,
  input  logic               tdi_i,
  input  logic [N_PORTS-1:0] lsp_tdo_i,
  output logic [N_PORTS-1:0] lsp_tdi_o,
  output logic [N_PORTS-1:0] lsp_tms_o,
  output logic               tdo_o
);
  logic [N_PORTS-1:0] mode, active, member;
  logic [N_SEC:0]     sec_link;
  logic [N_SEC-1:0]   sec_bypass;
  logic               mode_sout, own_q, all_bypass, chain_out;

  lsp_mode_reg #(.WIDTH(N_PORTS)) u_mode (
    .clk_i, .rst_ni, .tap_state_i, .ir_i, .tdi_i,
    .mode_o(mode), .sout_o(mode_sout)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_park
    lsp_park_port u_park (
      .clk_i, .rst_ni, .tap_state_i, .ir_i,
      .sel_i(mode[p]), .tms_i,
      .tms_o(lsp_tms_o[p]), .active_o(active[p])
    );
  end

  assign member      = active & mode;
  assign sec_link[0] = tdi_i;

  for (genvar s = 0; s < N_SEC; s++) begin : g_sec
    lsp_chain_section #(.PORTS(SEC_PORTS)) u_sec (
      .clk_i, .rst_ni,
      .member_i (member[s*SEC_PORTS +: SEC_PORTS]),
      .sdi_i    (sec_link[s]),
      .lsp_tdo_i(lsp_tdo_i[s*SEC_PORTS +: SEC_PORTS]),
      .lsp_tdi_o(lsp_tdi_o[s*SEC_PORTS +: SEC_PORTS]),
      .sdo_o    (sec_link[s+1]),
      .bypass_o (sec_bypass[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) own_q <= 1'b0;
    else         own_q <= tdi_i;
  end

  assign all_bypass = &sec_bypass;
  assign chain_out  = all_bypass ? own_q : sec_link[N_SEC];
  assign tdo_o      = (ir_i == OP_MODE) ? mode_sout : chain_out;

  AST_LOOP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_bypass && ir_i != OP_MODE) |=>
      (!all_bypass || ir_i == OP_MODE || tdo_o == $past(tdi_i))); // R4
endmodule

// File: tb/sim_lsp_chain_builder.sv
module sim_lsp_chain_builder;
  import lsp_gw_pkg::*;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] tap_state_i = TS_RTI;
  logic [7:0] ir_i = 8'hFF;
  logic       tms_i = 1'b0;
  logic       tdi_i = 1'b0;
  logic [5:0] lsp_tdo_i, lsp_tdi_o, lsp_tms_o;
  logic       tdo_o;
  int         n_tests = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk_i = ~clk_i;
  assign lsp_tdo_i = lsp_tdi_o;  // ports looped back

  lsp_chain_builder u0 (.*);

  // {mode, expected path delay}
  localparam logic [9:0] VEC [8] = '{
    {6'b000001, 4'd1}, {6'b000101, 4'd2}, {6'b000111, 4'd3}, {6'b111000, 4'd3},
    {6'b101010, 4'd3}, {6'b111111, 4'd6}, {6'b100001, 4'd2}, {6'b000000, 4'd1}};

  task automatic clk1; @(posedge clk_i); @(negedge clk_i); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_mode(input logic [5:0] m);
    ir_i = OP_MODE; tap_state_i = TS_CDR; clk1();
    tap_state_i = TS_SDR;
    for (int i = 0; i < 6; i++) begin tdi_i = m[i]; clk1(); end
    tap_state_i = TS_UDR; clk1();
    tap_state_i = TS_RTI; ir_i = 8'hFF; tdi_i = 1'b0; clk1();
  endtask

  task automatic read_mode(output logic [5:0] m);
    ir_i = OP_MODE; tdi_i = 1'b0; tap_state_i = TS_CDR; clk1();
    tap_state_i = TS_SDR;
    for (int i = 0; i < 6; i++) begin m[i] = tdo_o; clk1(); end
    tap_state_i = TS_RTI; ir_i = 8'hFF; clk1();
  endtask

  task automatic issue(input logic [7:0] op);
    ir_i = op; tap_state_i = TS_UIR; clk1();
    tap_state_i = TS_RTI; ir_i = 8'hFF; clk1();
  endtask

  task automatic delay_of(output int n);
    tdi_i = 1'b0;
    for (int i = 0; i < 8; i++) clk1();
    tdi_i = 1'b1; n = 0;
    for (int i = 0; i < 10; i++) begin
      clk1(); n++;
      if (tdo_o === 1'b1) break;
    end
    tdi_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int d;
    logic [5:0] m;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset state
    chk("R1 tms parked", lsp_tms_o, 6'b111111);
    read_mode(m); chk("R1 mode zero", m, 6'b0);
    delay_of(d); chk("R1 own loop", d, 1);

    // R2: mode write and readback
    load_mode(6'b101101); read_mode(m); chk("R2 readback", m, 6'b101101);

    // R5: unpark everything
    load_mode(6'b111111); issue(OP_UNPARK);
    // R9: follow primary tms
    tms_i = 1'b1; #1 chk("R9 follow high", lsp_tms_o, 6'b111111);
    tms_i = 1'b0; #1 chk("R9 follow low", lsp_tms_o, 6'b000000);

    // R3/R4: table of mode values against path delay
    for (int v = 0; v < 8; v++) begin
      load_mode(VEC[v][9:4]);
      delay_of(d);
      chk($sformatf("R3 delay mode=%b", VEC[v][9:4]), d, VEC[v][3:0]);
      for (int p = 0; p < 6; p++)
        if (!VEC[v][4+p]) chk($sformatf("R10 idle port %0d", p), lsp_tdi_o[p], 1'b1);
    end

    // R3: order across sections, port 0 before port 5
    load_mode(6'b100001);
    tdi_i = 1'b0;
    for (int i = 0; i < 8; i++) clk1();
    tdi_i = 1'b1; #1
    chk("R3 first port", lsp_tdi_o[0], 1'b1);
    chk("R3 later port waits", lsp_tdi_o[5], 1'b0);
    clk1(); chk("R3 later port after pad", lsp_tdi_o[5], 1'b1);
    tdi_i = 1'b0;

    // R6: park port 1 in test-logic-reset
    load_mode(6'b000010); issue(OP_PARK_TLR);
    tms_i = 1'b0; #1 chk("R6 tms held", lsp_tms_o[1:0], 2'b10);
    load_mode(6'b000111); delay_of(d); chk("R6 left chain", d, 2);

    // R7: park port 2 in run-test-idle
    load_mode(6'b000100);
    ir_i = OP_PARK_RTI; tap_state_i = TS_UIR; clk1();
    ir_i = 8'hFF; tap_state_i = TS_SELDR; tms_i = 1'b1; #1
    chk("R7 pending follows", lsp_tms_o[2], 1'b1);
    clk1(); tap_state_i = TS_RTI; tms_i = 1'b0; clk1();
    tms_i = 1'b1; #1 chk("R7 held low", lsp_tms_o[2], 1'b0);
    tms_i = 1'b0;

    // R8: park port 3 at a pause state
    load_mode(6'b001000);
    ir_i = OP_PARK_PAUSE; tap_state_i = TS_UIR; clk1();
    ir_i = 8'hFF; tap_state_i = TS_SELDR; tms_i = 1'b1; #1
    chk("R8 pending follows", lsp_tms_o[3], 1'b1);
    clk1(); tap_state_i = TS_PDR; tms_i = 1'b0; clk1();
    tap_state_i = TS_E2DR; tms_i = 1'b1; clk1(); clk1();
    chk("R8 held after leaving pause", lsp_tms_o[3], 1'b0);
    tap_state_i = TS_RTI; tms_i = 1'b0; clk1();

    // R5: unpark only port 2; ports 1 and 3 stay parked
    load_mode(6'b000100); issue(OP_UNPARK);
    tms_i = 1'b0; #1 chk("R5 selective low", lsp_tms_o, 6'b000010);
    tms_i = 1'b1; #1 chk("R5 selective high", lsp_tms_o, 6'b110111);
    tms_i = 1'b0;

    // R11: unknown opcode changes nothing
    load_mode(6'b111111); issue(8'h00); issue(8'h5A);
    #1 chk("R11 park kept low", lsp_tms_o, 6'b000010);
    tms_i = 1'b1; #1 chk("R11 park kept high", lsp_tms_o, 6'b110111);
    tms_i = 1'b0;

    // R2/R4: test-logic-reset clears the mode, chain collapses to own flop
    tap_state_i = TS_TLR; clk1(); tap_state_i = TS_RTI; clk1();
    read_mode(m); chk("R2 cleared by TLR", m, 6'b0);
    delay_of(d); chk("R4 all bypassed", d, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule